// File: doc/BRIEF.md
# Two-Level Trigger Event Queue Manager

This block keeps one event record per beam tick while two successive trigger levels make up their minds about it. Each tick a new record enters a delay line whose length is programmed to match the first-level decision latency. When the first-level accept arrives on a tick, the record that has just reached the programmed depth is copied into a second-level pending FIFO. Each second-level decision removes the oldest pending record. An accept sends it to a readout FIFO. A reject throws it away.

A host drains the readout FIFO through a valid/ready output stream. `ro_valid` is high whenever the readout FIFO holds a record, and `ro_data` then shows the oldest one. A record is removed on any clock where both `ro_valid` and `ro_ready` are high. Holding `ro_ready` low stalls the stream with no loss. While the FIFO is empty, `ro_data` reads as zero. Occupancy and both pointers of each FIFO are visible as plain outputs. A single sticky error flag collects three fault conditions. An initialize input empties everything and loads a new delay length.

Top module: `trig_event_queue`

## Requirements
- R1: A record presented with `tick` is offered to the first-level stage on the tick exactly L ticks later. L is loaded from `dly_len` only while `init` is high. A value of 0 is taken as 1 and values above 32 are taken as 32. L is 1 after reset, and `dly_len` has no effect at any other time.
- R2: `tick` together with `l1_accept` appends the record offered at that tick to the second-level FIFO, keeping arrival order. `l1_accept` without `tick` does nothing. An accept at a depth that holds no record since the last initialize also does nothing.
- R3: `l2_decision` removes the oldest second-level record. If `l2_accept` is high in that cycle, the record is appended to the readout FIFO. Otherwise it is discarded.
- R4: If a first-level transfer meets a second-level FIFO that already holds 16 records, the new record is lost, the FIFO is left unchanged and `err` is set.
- R5: `l2_decision` while the second-level FIFO is empty sets `err` and moves nothing.
- R6: An accepted second-level decision while the readout FIFO holds 16 records still removes the pending record. The record is lost and `err` is set.
- R7: `err` stays high until `init` or `err_clr`. A new error condition in the same cycle as `err_clr` leaves `err` high.
- R8: `init` empties the delay line, both FIFOs and all pointers, and clears `err`. In that cycle every other input is ignored.
- R9: `ro_valid` is high exactly when the readout FIFO is non-empty. `ro_data` shows the oldest record, or zero when the FIFO is empty. A pop happens only when `ro_valid` and `ro_ready` are both high.
- R10: The `*_level` outputs give the record count of each FIFO (0 to 16). The `*_wr_ptr` and `*_rd_ptr` outputs count writes and reads modulo 16, starting from 0 after reset or initialize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Empty all queues, clear error, load delay length |
| dly_len | input | 6 | Delay length in ticks, sampled on init |
| tick | input | 1 | Beam tick strobe: shift record in |
| rec_in | input | 16 | Record for this tick |
| l1_accept | input | 1 | First-level accept, qualified by tick |
| l2_decision | input | 1 | Second-level decision strobe |
| l2_accept | input | 1 | Second-level verdict, used with l2_decision |
| err_clr | input | 1 | Clear sticky error |
| ro_ready | input | 1 | Host ready to take a readout record |
| ro_valid | output | 1 | Readout FIFO non-empty |
| ro_data | output | 16 | Oldest readout record, zero when empty |
| l2_wr_ptr | output | 4 | Second-level FIFO write pointer |
| l2_rd_ptr | output | 4 | Second-level FIFO read pointer |
| l2_level | output | 5 | Second-level FIFO occupancy |
| ro_wr_ptr | output | 4 | Readout FIFO write pointer |
| ro_rd_ptr | output | 4 | Readout FIFO read pointer |
| ro_level | output | 5 | Readout FIFO occupancy |
| err | output | 1 | Sticky error flag |

## Verification
A delay tap that is off by one shifts every transferred record to its neighbour's value. This shows on `ro_data` at the first readout, together with a wrong `l2_level` on the cycle after the first accept. A full or empty test that is off by one shows in the next cycle as a level of 17 or as a missing `err`. A pointer that fails to wrap shows as a wrong pointer value after the sixteenth write. The model tracks every level, pointer and the error flag after every clock, so any such fault is caught one cycle after it occurs.

// File: rtl/tq_pkg.sv
package tq_pkg;
  // Clamp a requested delay length into 1..max_len
  function automatic logic [5:0] clamp_len(input logic [5:0] v, input logic [5:0] max_len);
    if (v == 6'd0)
      return 6'd1;
    else if (v > max_len)
      return max_len;
    else
      return v;
  endfunction
endpackage

// File: rtl/tq_delay.sv
module tq_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [W-1:0]  in_data,
  input  logic [SW-1:0] tap,
  output logic [W-1:0]  out_data,
  output logic          out_valid
);
  logic [W-1:0]     dat [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld <= '0;
    else if (clr)
      vld <= '0;
    else if (shift)
      vld <= {vld[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (shift && !clr) dat[0] <= in_data;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (shift && !clr) dat[i] <= dat[i-1];
    end
  end

  assign out_data  = dat[tap];
  assign out_valid = vld[tap];

  // R1
  shift_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr && vld[0]) |=> (vld[1] && dat[1] == $past(dat[0])));
endmodule

// File: rtl/tq_fifo.sv
module tq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full,
  output logic          empty
);
  logic [W-1:0] mem [DEPTH];
  logic do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      level <= level + LW'(1);
      else if (do_pop && !do_push) level <= level - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (level == LW'(DEPTH)));
endmodule

// File: rtl/trig_event_queue.sv
module trig_event_queue #(
  parameter int REC_W    = 16,
  parameter int MAX_DLY  = 32,
  parameter int L2_DEPTH = 16,
  parameter int RO_DEPTH = 16,
  localparam int DLY_W   = $clog2(MAX_DLY + 1),
  localparam int SW      = $clog2(MAX_DLY),
  localparam int L2_AW   = $clog2(L2_DEPTH),
  localparam int RO_AW   = $clog2(RO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [DLY_W-1:0] dly_len,
  input  logic             tick,
  input  logic [REC_W-1:0] rec_in,
  input  logic             l1_accept,
  input  logic             l2_decision,
  input  logic             l2_accept,
  input  logic             err_clr,
  input  logic             ro_ready,
  output logic             ro_valid,
  output logic [REC_W-1:0] ro_data,
  output logic [L2_AW-1:0] l2_wr_ptr,
  output logic [L2_AW-1:0] l2_rd_ptr,
  output logic [L2_AW:0]   l2_level,
  output logic [RO_AW-1:0] ro_wr_ptr,
  output logic [RO_AW-1:0] ro_rd_ptr,
  output logic [RO_AW:0]   ro_level,
  output logic             err
);
  import tq_pkg::*;

  logic [DLY_W-1:0] len_q, len_m1, len_new;
  logic [REC_W-1:0] tap_data, l2_head, ro_head;
  logic tap_valid, l2_full, l2_empty, ro_full, ro_empty;
  logic l1_push, l2_pop, ro_push, ro_pop;
  logic ovf, unf, ro_drop;

  assign len_new = DLY_W'(clamp_len(6'(dly_len), 6'(MAX_DLY)));
  assign len_m1  = len_q - DLY_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= DLY_W'(1);
    else if (init) len_q <= len_new;
  end

  tq_delay #(.W(REC_W), .DEPTH(MAX_DLY)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(init), .shift(tick), .in_data(rec_in),
    .tap(len_m1[SW-1:0]), .out_data(tap_data), .out_valid(tap_valid));

  assign l1_push = tick && l1_accept && tap_valid && !init;
  assign l2_pop  = l2_decision && !l2_empty && !init;
  assign ro_push = l2_pop && l2_accept;
  assign ro_pop  = ro_valid && ro_ready && !init;

  tq_fifo #(.W(REC_W), .DEPTH(L2_DEPTH)) u_l2 (
    .clk(clk), .rst_n(rst_n), .clr(init), .push(l1_push), .push_data(tap_data),
    .pop(l2_pop), .head(l2_head), .level(l2_level), .wr_ptr(l2_wr_ptr),
    .rd_ptr(l2_rd_ptr), .full(l2_full), .empty(l2_empty));

  tq_fifo #(.W(REC_W), .DEPTH(RO_DEPTH)) u_ro (
    .clk(clk), .rst_n(rst_n), .clr(init), .push(ro_push), .push_data(l2_head),
    .pop(ro_pop), .head(ro_head), .level(ro_level), .wr_ptr(ro_wr_ptr),
    .rd_ptr(ro_rd_ptr), .full(ro_full), .empty(ro_empty));

  assign ro_valid = !ro_empty;
  assign ro_data  = ro_empty ? '0 : ro_head;

  assign ovf     = l1_push && l2_full;
  assign unf     = l2_decision && l2_empty && !init;
  assign ro_drop = ro_push && ro_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err <= 1'b0;
    else if (init)              err <= 1'b0;
    else if (ovf || unf || ro_drop) err <= 1'b1;
    else if (err_clr)           err <= 1'b0;
  end

  // R5
  underflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_decision && !init && l2_level == '0) |=> err);
  // R6
  ro_full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_decision && l2_accept && !init && l2_level != '0 && ro_level == (RO_AW+1)'(RO_DEPTH)) |=> err);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !init && !err_clr) |=> err);
  // R8
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (l2_level == '0 && ro_level == '0 && !err && !ro_valid));
endmodule

// File: tb/test_trig_event_queue.sv
module test_trig_event_queue;
  logic clk = 0, rst_n = 0;
  logic init = 0, tick = 0, l1_accept = 0, l2_decision = 0, l2_accept = 0, err_clr = 0, ro_ready = 0;
  logic [5:0]  dly_len = 6'd1;
  logic [15:0] rec_in = '0;
  logic ro_valid, err;
  logic [15:0] ro_data;
  logic [3:0] l2_wr_ptr, l2_rd_ptr, ro_wr_ptr, ro_rd_ptr;
  logic [4:0] l2_level, ro_level;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [15:0] h_dat [32];
  logic        h_vld [32];
  int lenm = 1;
  logic [15:0] l2q[$];
  logic [15:0] roq[$];
  int l2w = 0, l2r = 0, row = 0, ror = 0;
  bit errm = 0;

  always #2 clk = ~clk;

  trig_event_queue i_trig_event_queue (
    .clk(clk), .rst_n(rst_n), .init(init), .dly_len(dly_len), .tick(tick), .rec_in(rec_in),
    .l1_accept(l1_accept), .l2_decision(l2_decision), .l2_accept(l2_accept), .err_clr(err_clr),
    .ro_ready(ro_ready), .ro_valid(ro_valid), .ro_data(ro_data),
    .l2_wr_ptr(l2_wr_ptr), .l2_rd_ptr(l2_rd_ptr), .l2_level(l2_level),
    .ro_wr_ptr(ro_wr_ptr), .ro_rd_ptr(ro_rd_ptr), .ro_level(ro_level), .err(err));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state();
    chk("R7", "err", int'(err), int'(errm));
    chk("R10", "l2_level", int'(l2_level), l2q.size());
    chk("R10", "ro_level", int'(ro_level), roq.size());
    chk("R10", "l2_wr_ptr", int'(l2_wr_ptr), l2w);
    chk("R10", "l2_rd_ptr", int'(l2_rd_ptr), l2r);
    chk("R10", "ro_wr_ptr", int'(ro_wr_ptr), row);
    chk("R10", "ro_rd_ptr", int'(ro_rd_ptr), ror);
    chk("R9", "ro_valid", int'(ro_valid), int'(roq.size() > 0));
    chk("R9", "ro_data", int'(ro_data), roq.size() > 0 ? int'(roq[0]) : 0);
  endtask

  // one clock of stimulus; model updated from pre-edge state
  task automatic step(input bit t, input logic [15:0] r, input bit a1, input bit d2,
                      input bit a2, input bit rd, input bit in, input bit ec, input logic [5:0] len);
    int l2n, ron;
    bit set;
    logic [15:0] x;
    tick = t; rec_in = r; l1_accept = a1; l2_decision = d2; l2_accept = a2;
    ro_ready = rd; init = in; err_clr = ec; dly_len = len;
    @(negedge clk);
    // scoreboard monitor: pop expected item on a read
    if (rd && !in) begin
      chk("R9", "read valid", int'(ro_valid), int'(roq.size() > 0));
      chk("R3", "read data", int'(ro_data), roq.size() > 0 ? int'(roq[0]) : 0);
    end
    if (in) begin
      for (int i = 0; i < 32; i++) h_vld[i] = 0;
      l2q.delete(); roq.delete();
      l2w = 0; l2r = 0; row = 0; ror = 0; errm = 0;
      lenm = (len == 0) ? 1 : (len > 32) ? 32 : int'(len);
    end else begin
      l2n = l2q.size(); ron = roq.size(); set = 0;
      if (rd && ron > 0) begin x = roq.pop_front(); ror = (ror + 1) % 16; end
      if (d2) begin
        if (l2n == 0) set = 1;
        else begin
          x = l2q.pop_front(); l2r = (l2r + 1) % 16;
          if (a2) begin
            if (ron == 16) set = 1;
            else begin roq.push_back(x); row = (row + 1) % 16; end
          end
        end
      end
      if (t && a1 && h_vld[lenm-1]) begin
        if (l2n == 16) set = 1;
        else begin l2q.push_back(h_dat[lenm-1]); l2w = (l2w + 1) % 16; end
      end
      if (set) errm = 1; else if (ec) errm = 0;
      if (t) begin
        for (int i = 31; i > 0; i--) begin h_dat[i] = h_dat[i-1]; h_vld[i] = h_vld[i-1]; end
        h_dat[0] = r; h_vld[0] = 1;
      end
    end
    @(posedge clk); #1;
    check_state();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, dly_len);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin h_vld[i] = 0; h_dat[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check_state(); // R8 reset state, R1 len 1

    // R1 R2 R3: delay 3, mixed accepts
    step(0, 0, 0, 0, 0, 0, 1, 0, 6'd3);
    for (int i = 0; i < 12; i++) step(1, 16'h100 + 16'(i), (i % 3) != 1, 0, 0, 0, 0, 0, 6'd3);
    step(0, 0, 1, 0, 0, 0, 0, 0, 6'd9);        // R2 l1 without tick ignored; R1 len unaffected
    step(1, 16'h1ff, 1, 1, 1, 0, 0, 0, 6'd9);  // push and pop same cycle
    step(0, 0, 0, 1, 0, 0, 0, 0, 6'd9);        // R3 reject drops
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, i[0], 1, 0, 0, 6'd9);
    idle(2);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 6'd9); // R9 drain, read empty

    // R5 R7: underflow and sticky error
    while (l2q.size() > 0) step(0, 0, 0, 1, 0, 0, 0, 0, 6'd9);
    step(0, 0, 0, 1, 1, 0, 0, 0, 6'd9);
    idle(3);
    step(0, 0, 0, 1, 0, 0, 0, 1, 6'd9);        // R7 set wins over clear
    step(0, 0, 0, 0, 0, 0, 0, 1, 6'd9);        // R7 clear

    // R4: overflow with delay 1 (0 clamps to 1)
    step(0, 0, 0, 0, 0, 0, 1, 0, 6'd0);
    for (int i = 0; i < 20; i++) step(1, 16'h200 + 16'(i), 1, 0, 0, 0, 0, 0, 6'd0);

    // R6: move all 16 to readout, then accept into full readout
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 1, 0, 0, 1, 6'd0);
    for (int i = 0; i < 3; i++) step(1, 16'h300 + 16'(i), 1, 0, 0, 0, 0, 0, 6'd0);
    step(0, 0, 0, 1, 1, 0, 0, 0, 6'd0);
    step(0, 0, 0, 1, 1, 1, 0, 0, 6'd0);        // read and full-accept in one cycle
    for (int i = 0; i < 17; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 6'd0);

    // R1: length above 32 clamps to 32
    step(0, 0, 0, 0, 0, 0, 1, 0, 6'd45);
    for (int i = 0; i < 36; i++) step(1, 16'h400 + 16'(i), 1, 0, 0, 0, 0, 0, 6'd5);
    chk("R1", "first record after 32 ticks", int'(l2q.size() > 0 ? l2q[0] : 0), 'h400);

    // R8: init overrides everything in the same cycle
    step(0, 0, 0, 0, 0, 0, 0, 0, 6'd5);
    step(0, 0, 0, 1, 1, 0, 0, 0, 6'd5);
    step(1, 16'h5aa, 1, 1, 1, 1, 1, 0, 6'd2);
    for (int i = 0; i < 4; i++) step(1, 16'h600 + 16'(i), 1, 0, 0, 0, 0, 0, 6'd2);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 1, 0, 0, 6'd2);
    idle(1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule